// File: doc/BRIEF.md
# Burst Address Sequencer (Linear / Interleaved)

This block produces the address sequence of a four-beat memory burst. A controller presents a starting address and issues a load; each later advance steps the two least significant address bits to the next beat of the burst, while the remaining address bits stay at the value captured at load time. A beat index reports which beat of the burst is current.

Two beat orders are supported, picked by a mode input that is expected to be tied to a fixed level. In linear order the low bits count upward from the start value and wrap modulo four. In interleaved order the low bits are the start value XORed with the beat index. A suspend input freezes the whole sequencer for as long as it is high, so a burst can be stretched across stalls without losing its place.

All state is registered on the rising clock edge; the outputs are decoded from that state, so a load or advance shows up on the outputs right after the edge that samples it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the state clears so that `addr_o` is all zeros and `beat_o` is 0 after that edge.
- R2: With `suspend` low and `adv` low at an edge, `addr_o` equals `start_addr` and `beat_o` is 0 after that edge.
- R3: With `suspend` low and `adv` high at an edge, `beat_o` increases by one modulo 4 (3 rolls over to 0 with no other effect).
- R4: With `ilv_mode` = 0 (linear), the low two bits of `addr_o` equal (start low bits + `beat_o`) modulo 4; from start 01 the beats are 01, 10, 11, 00.
- R5: With `ilv_mode` = 1 (interleaved), the low two bits of `addr_o` equal start low bits XOR `beat_o`; from start 01 the beats are 01, 00, 11, 10.
- R6: After four advances following a load, `addr_o` is back at the loaded start address.
- R7: While `suspend` is high at an edge, `addr_o` and `beat_o` keep their values whatever `adv` and `start_addr` carry.
- R8: Address bits above bit 1 stay at their loaded value during every advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | High freezes all state for the cycle |
| adv | input | 1 | Low loads `start_addr`, high steps to the next beat |
| ilv_mode | input | 1 | Static order select: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Burst starting address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |

## Verification
The assertions check on every cycle that a suspended cycle changes nothing, that a load lands the start address with beat zero, that an advance bumps the beat by one and leaves the upper bits alone, and that the low bits step by one in linear order while their XOR with the beat stays fixed in interleaved order. Only the bench scenarios show the full visiting order for each of the four start values in both modes, the return to the start address after the fourth advance, and that a stall in mid-burst resumes at the right beat.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Number of sequenced low address bits (four-beat burst).
    parameter int SEQ_W = 2;

    typedef logic [SEQ_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Decoded per-cycle control.
    typedef struct packed {
        logic hold;   // freeze all state
        logic load;   // capture start address, clear beat
        logic step;   // move to next beat
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic suspend, input logic adv);
        ctl_t c;
        c.hold = suspend;
        c.load = !suspend && !adv;
        c.step = !suspend && adv;
        return c;
    endfunction

    // Low address bits of the current beat for a given order.
    function automatic beat_t beat_addr(input beat_t base_lo, input beat_t beat,
                                        input order_e ord);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = base_lo ^ beat;
        else                       r = beat_t'(base_lo + beat);
        return r;
    endfunction

endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    output beat_t beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else if (ctl.load) begin
            beat <= '0;
        end else if (ctl.step) begin
            beat <= beat_t'(beat + 1'b1);
        end
    end
endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
        end else if (ctl.load) begin
            base <= start_addr;
        end
    end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  order_e            ord,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - SEQ_W;

    beat_t lo;

    always_comb begin
        lo = beat_addr(base[SEQ_W-1:0], beat, ord);
    end

    generate
        if (HI_W > 0) begin : g_hi
            assign addr = {base[ADDR_W-1:SEQ_W], lo};
        end else begin : g_lo_only
            assign addr = lo;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              suspend,
    input  logic              adv,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SEQ_W-1:0]  beat_o
);
    ctl_t              ctl;
    beat_t             beat;
    logic [ADDR_W-1:0] base;
    order_e            ord;

    always_comb begin
        ctl = decode_ctl(suspend, adv);
        ord = order_e'(ilv_mode);
    end

    bseq_beat_ctr u_beat (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .beat (beat)
    );

    bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .start_addr (start_addr),
        .base       (base)
    );

    bseq_order #(.ADDR_W(ADDR_W)) u_order (
        .base (base),
        .beat (beat),
        .ord  (ord),
        .addr (addr_o)
    );

    assign beat_o = beat;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              suspend,
    input logic              adv,
    input logic              ilv_mode,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] addr_o,
    input logic [SEQ_W-1:0]  beat_o
);
    logic [SEQ_W-1:0] lo;
    logic [SEQ_W-1:0] lo_x_beat;
    assign lo        = addr_o[SEQ_W-1:0];
    assign lo_x_beat = lo ^ beat_o;

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!suspend && !adv) |=> (addr_o == $past(start_addr) && beat_o == '0));

    assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!suspend && adv) |=> (beat_o == SEQ_W'($past(beat_o) + 1)));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!suspend && adv && !ilv_mode) |=> (ilv_mode || lo == SEQ_W'($past(lo) + 1)));

    assert_interleave_key_R5: assert property (@(posedge clk) disable iff (rst)
        (!suspend && adv && ilv_mode) |=> (!ilv_mode || lo_x_beat == $past(lo_x_beat)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        suspend |=> ($stable(addr_o) && $stable(beat_o)));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (!suspend && adv) |=> $stable(addr_o[ADDR_W-1:SEQ_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .suspend    (suspend),
    .adv        (adv),
    .ilv_mode   (ilv_mode),
    .start_addr (start_addr),
    .addr_o     (addr_o),
    .beat_o     (beat_o)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          suspend = 1'b0;
    logic          adv = 1'b0;
    logic          ilv_mode = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int n_checks = 0;
    int n_fail = 0;

    // Reference state
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .suspend(suspend), .adv(adv),
        .ilv_mode(ilv_mode), .start_addr(start_addr),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    task automatic check(input string tag, input logic [AW-1:0] act_a, input logic [AW-1:0] exp_a,
                         input int act_b, input int exp_b);
        n_checks++;
        if (act_a !== exp_a || act_b != exp_b) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, act_a, act_b, exp_a, exp_b);
        end
    endtask

    // One clock: update model at the edge, compare at the falling edge.
    task automatic tick(input string tag);
        logic [1:0]    lo;
        logic [AW-1:0] exp_a;
        @(posedge clk);
        if (rst) begin
            m_base = '0; m_cnt = 0;
        end else if (!suspend) begin
            if (!adv) begin m_base = start_addr; m_cnt = 0; end
            else m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        if (ilv_mode) lo = m_base[1:0] ^ 2'(m_cnt);
        else          lo = 2'((int'(m_base[1:0]) + m_cnt) % 4);
        exp_a = {m_base[AW-1:2], lo};
        check(tag, addr_o, exp_a, int'(beat_o), m_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] seen [4];
        logic [AW-1:0] st;
        string tg;
        start_addr = 19'h5A5A7;
        adv = 1'b1;
        tick("R1 reset");
        tick("R1 reset");
        rst = 1'b0;

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                ilv_mode = m[0];
                tg = (m == 0) ? "R4 linear" : "R5 interleaved";
                st = {17'(17'h0B3C1 + s * 17'h1111), 2'(s)};
                start_addr = st;
                adv = 1'b0;
                tick("R2 load");
                seen[0] = addr_o[1:0];
                adv = 1'b1;
                start_addr = ~st;
                tick(tg); seen[1] = addr_o[1:0];
                // stall mid-burst: inputs must have no effect
                suspend = 1'b1;
                adv = 1'b0;
                tick("R7 suspend");
                adv = 1'b1;
                tick("R7 suspend");
                suspend = 1'b0;
                tick(tg); seen[2] = addr_o[1:0];
                check("R8 upper bits", {addr_o[AW-1:2], 2'b00}, {st[AW-1:2], 2'b00}, 0, 0);
                tick(tg); seen[3] = addr_o[1:0];
                tick("R3 rollover");
                check("R6 wrap to start", addr_o, st, int'(beat_o), 0);
                // literal orders for start 01
                if (s == 1) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [1:0] e;
                        if (m == 0) e = 2'(1 + k);
                        else        e = 2'(1) ^ 2'(k);
                        check(m == 0 ? "R4 order from 01" : "R5 order from 01",
                              {{(AW-2){1'b0}}, seen[k]}, {{(AW-2){1'b0}}, e}, k, k);
                    end
                end
            end
        end

        // reset in mid-burst
        adv = 1'b0; start_addr = 19'h12345; tick("R2 load");
        adv = 1'b1; tick("R4 linear");
        rst = 1'b1; tick("R1 reset mid-burst");
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule